// File: doc/BRIEF.md
# DRAM Command Spacing Checker

This block observes a stream of decoded DRAM commands and reports any command issued too early relative to the commands before it. Each cycle it may see one command, given by a strobe, a 3-bit type and a bank index. It checks seven spacing rules:

- activate to activate
- at most four activates inside a rolling window
- column to column
- read after write data
- read to precharge on the same bank
- mode register set to mode register set
- mode register set to any other command

Where a rule has a time-based component, that component arrives on a configuration input as a cycle count that has already been computed. The block then enforces the larger of that count and a fixed cycle floor.

The command input is a pure observation port. The block never back-pressures, so there is no ready signal and a command is accepted in every cycle its strobe is high. A violation is reported as a one-cycle pulse together with a rule code. The command that caused the violation is still recorded in the history, exactly as a legal command would be. Spacing is measured as the difference between the cycle indices of the two commands.

Top module: `dcc_spacing_checker`

## Requirements
- R1: The command type codes are activate=0, read=1, write=2, precharge=3 and mode-register-set=4, and they count only while `cmd_valid` is high. The result for a command appears on `viol_valid`/`viol_code` in the cycle after the command is sampled and lasts exactly one cycle. `viol_code` is 0 whenever `viol_valid` is low.
- R2: An activate whose spacing from the previous activate is less than max(4, `cfg_rrd`) is flagged with code 4.
- R3: Four activates are kept in a history. An activate is flagged with code 3 when that history is full and the oldest entry is fewer than `cfg_faw` cycles old. A spacing exactly equal to `cfg_faw` is legal.
- R4: A read or write whose spacing from the previous read or write is less than 4 is flagged with code 6.
- R5: A read whose spacing from the last write is less than `cfg_wdata` + max(4, `cfg_wtr`) is flagged with code 5.
- R6: A precharge to bank b whose spacing from the last read to bank b is less than max(4, `cfg_rtp`) is flagged with code 7. Reads to other banks have no effect on this check.
- R7: A mode-register-set whose spacing from the previous mode-register-set is less than 4 is flagged with code 2.
- R8: Any other command whose spacing from the last mode-register-set is less than max(12, `cfg_mod`) is flagged with code 1.
- R9: When several rules are broken at once, the lowest code is reported.
- R10: A flagged command is recorded in every history it belongs to, in the same way as a legal command.
- R11: A synchronous reset clears all history, so the first command of each kind after reset is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | 3 | Command type code |
| cmd_bank | input | BANK_W | Bank index |
| cfg_rrd | input | CNT_W | Activate-to-activate cycles |
| cfg_faw | input | CNT_W | Four-activate window in cycles |
| cfg_wdata | input | CNT_W | Cycles from a write command to the end of its data |
| cfg_wtr | input | CNT_W | Write-data-end to read cycles |
| cfg_rtp | input | CNT_W | Read-to-precharge cycles |
| cfg_mod | input | CNT_W | Mode-register-set to other-command cycles |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Code of the broken rule, 0 when there is no violation |

## Verification
The assertions assume that no command is presented while reset is high. They also assume the configuration inputs hold steady and keep `cfg_wdata` plus the turnaround below 2^CNT_W. Under these conditions, two activates, or two column commands, in back-to-back cycles must always produce a pulse. The stimulus drives the strobe only after reset has been released, holds every configuration value constant, and places commands exactly on each limit, just inside it and just outside it.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [2:0] {
    CMD_ACT = 3'd0,
    CMD_RD  = 3'd1,
    CMD_WR  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_MRS = 3'd4
  } dcc_cmd_e;

  typedef enum logic [2:0] {
    RULE_NONE = 3'd0,
    RULE_MOD  = 3'd1,
    RULE_MRD  = 3'd2,
    RULE_FAW  = 3'd3,
    RULE_RRD  = 3'd4,
    RULE_WTR  = 3'd5,
    RULE_CCD  = 3'd6,
    RULE_RTP  = 3'd7
  } dcc_rule_e;
endpackage

// File: rtl/dcc_gap_tracker.sv
module dcc_gap_tracker #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  output logic         seen,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] AGE_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      age  <= '0;
    end else if (hit) begin
      seen <= 1'b1;
      age  <= W'(1);
    end else if (seen && age != AGE_MAX) begin
      age  <= age + W'(1);
    end
  end

  // R10
  hit_age_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (seen && age == W'(1)));
endmodule

// File: rtl/dcc_act_window.sv
module dcc_act_window #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         act,
  input  logic [W-1:0] window,
  output logic         too_soon
);
  localparam logic [W-1:0] AGE_MAX = '1;

  logic [W-1:0]     age_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] a);
    return (a == AGE_MAX) ? a : a + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) age_q[i] <= '0;
    end else if (act) begin
      vld_q <= {vld_q[DEPTH-2:0], 1'b1};
      age_q[0] <= W'(1);
      for (int i = 1; i < DEPTH; i++) age_q[i] <= sat_inc(age_q[i-1]);
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (vld_q[i]) age_q[i] <= sat_inc(age_q[i]);
    end
  end

  assign too_soon = vld_q[DEPTH-1] && (age_q[DEPTH-1] < window);

  // R3
  faw_full_chk: assert property (@(posedge clk) disable iff (rst)
    (act && (&vld_q)) |=> (&vld_q));
endmodule

// File: rtl/dcc_spacing_checker.sv
module dcc_spacing_checker
  import dcc_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int CNT_W     = 8,
  parameter int FAW_DEPTH = 4,
  parameter int RRD_FLOOR = 4,
  parameter int CCD_MIN   = 4,
  parameter int WTR_FLOOR = 4,
  parameter int RTP_FLOOR = 4,
  parameter int MRD_MIN   = 4,
  parameter int MOD_FLOOR = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_type,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [CNT_W-1:0]  cfg_rrd,
  input  logic [CNT_W-1:0]  cfg_faw,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic [CNT_W-1:0]  cfg_wtr,
  input  logic [CNT_W-1:0]  cfg_rtp,
  input  logic [CNT_W-1:0]  cfg_mod,
  output logic              viol_valid,
  output logic [2:0]        viol_code
);
  localparam int NBANK = 1 << BANK_W;

  logic act_hit, rd_hit, wr_hit, pre_hit, mrs_hit, col_hit, any_hit;
  assign act_hit = cmd_valid && cmd_type == CMD_ACT;
  assign rd_hit  = cmd_valid && cmd_type == CMD_RD;
  assign wr_hit  = cmd_valid && cmd_type == CMD_WR;
  assign pre_hit = cmd_valid && cmd_type == CMD_PRE;
  assign mrs_hit = cmd_valid && cmd_type == CMD_MRS;
  assign col_hit = rd_hit || wr_hit;
  assign any_hit = act_hit || col_hit || pre_hit;

  function automatic logic [CNT_W-1:0] lim(input logic [CNT_W-1:0] c, input int fl);
    return (c > CNT_W'(fl)) ? c : CNT_W'(fl);
  endfunction

  logic [CNT_W-1:0] rrd_lim, rtp_lim, mod_lim;
  logic [CNT_W:0]   wtr_lim;
  assign rrd_lim = lim(cfg_rrd, RRD_FLOOR);
  assign rtp_lim = lim(cfg_rtp, RTP_FLOOR);
  assign mod_lim = lim(cfg_mod, MOD_FLOOR);
  assign wtr_lim = {1'b0, cfg_wdata} + {1'b0, lim(cfg_wtr, WTR_FLOOR)};

  logic act_seen, col_seen, wr_seen, mrs_seen;
  logic [CNT_W-1:0] act_age, col_age, wr_age, mrs_age;

  dcc_gap_tracker #(.W(CNT_W)) u_act (.clk(clk), .rst(rst), .hit(act_hit), .seen(act_seen), .age(act_age));
  dcc_gap_tracker #(.W(CNT_W)) u_col (.clk(clk), .rst(rst), .hit(col_hit), .seen(col_seen), .age(col_age));
  dcc_gap_tracker #(.W(CNT_W)) u_wr  (.clk(clk), .rst(rst), .hit(wr_hit),  .seen(wr_seen),  .age(wr_age));
  dcc_gap_tracker #(.W(CNT_W)) u_mrs (.clk(clk), .rst(rst), .hit(mrs_hit), .seen(mrs_seen), .age(mrs_age));

  logic [NBANK-1:0] rd_seen;
  logic [CNT_W-1:0] rd_age [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_rd;
    assign bank_rd = rd_hit && cmd_bank == BANK_W'(b);
    dcc_gap_tracker #(.W(CNT_W)) u_rd (
      .clk(clk), .rst(rst), .hit(bank_rd), .seen(rd_seen[b]), .age(rd_age[b]));
  end

  logic faw_soon;
  dcc_act_window #(.W(CNT_W), .DEPTH(FAW_DEPTH)) u_faw (
    .clk(clk), .rst(rst), .act(act_hit), .window(cfg_faw), .too_soon(faw_soon));

  logic v_mod, v_mrd, v_faw, v_rrd, v_wtr, v_ccd, v_rtp;
  assign v_mod = any_hit && mrs_seen && mrs_age < mod_lim;
  assign v_mrd = mrs_hit && mrs_seen && mrs_age < CNT_W'(MRD_MIN);
  assign v_faw = act_hit && faw_soon;
  assign v_rrd = act_hit && act_seen && act_age < rrd_lim;
  assign v_wtr = rd_hit && wr_seen && {1'b0, wr_age} < wtr_lim;
  assign v_ccd = col_hit && col_seen && col_age < CNT_W'(CCD_MIN);
  assign v_rtp = pre_hit && rd_seen[cmd_bank] && rd_age[cmd_bank] < rtp_lim;

  dcc_rule_e code_d;
  always_comb begin
    if (v_mod)      code_d = RULE_MOD;
    else if (v_mrd) code_d = RULE_MRD;
    else if (v_faw) code_d = RULE_FAW;
    else if (v_rrd) code_d = RULE_RRD;
    else if (v_wtr) code_d = RULE_WTR;
    else if (v_ccd) code_d = RULE_CCD;
    else if (v_rtp) code_d = RULE_RTP;
    else            code_d = RULE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_valid <= 1'b0;
      viol_code  <= 3'd0;
    end else begin
      viol_valid <= code_d != RULE_NONE;
      viol_code  <= code_d;
    end
  end

  // R1
  pulse_code_chk: assert property (@(posedge clk) disable iff (rst)
    viol_valid == (viol_code != 3'd0));
  // R1
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> $past(cmd_valid));
  // R2
  act_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (act_hit && $past(act_hit)) |=> viol_valid);
  // R4
  col_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (col_hit && $past(col_hit)) |=> viol_valid);
  // R7
  mrs_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (mrs_hit && $past(mrs_hit)) |=> (viol_valid && viol_code == 3'd2));
endmodule

// File: tb/sim_dcc_spacing_checker.sv
module sim_dcc_spacing_checker;
  localparam int BANK_W = 3;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_type = 3'd0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic viol_valid;
  logic [2:0] viol_code;

  always #5 clk = ~clk;

  dcc_spacing_checker #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
    .cfg_rrd(8'd3), .cfg_faw(8'd20), .cfg_wdata(8'd8), .cfg_wtr(8'd5),
    .cfg_rtp(8'd3), .cfg_mod(8'd10),
    .viol_valid(viol_valid), .viol_code(viol_code));

  typedef struct { logic [2:0] code; string tag; } item_t;
  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [2:0] ACT = 3'd0, RD = 3'd1, WR = 3'd2, PRE = 3'd3, MRS = 3'd4;

  task automatic issue(input logic [2:0] t, input int b, input logic [2:0] ec, input string tag);
    item_t it;
    @(negedge clk);
    rst = 1'b0; cmd_valid = 1'b1; cmd_type = t; cmd_bank = BANK_W'(b);
    it.code = ec; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input bit hold_rst);
    for (int i = 0; i < n; i++) begin
      item_t it;
      @(negedge clk);
      rst = hold_rst; cmd_valid = 1'b0;
      it.code = 3'd0; it.tag = hold_rst ? "R11 reset" : "R1 idle";
      q.push_back(it);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (viol_valid !== (it.code != 3'd0) || viol_code !== it.code) begin
          errors++;
          $display("FAIL %s: got valid=%0b code=%0d, expected valid=%0b code=%0d",
                   it.tag, viol_valid, viol_code, it.code != 3'd0, it.code);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (viol_valid !== 1'b0 || viol_code !== 3'd0) begin
      errors++;
      $display("FAIL R11 reset state: got %0b/%0d, expected 0/0", viol_valid, viol_code);
    end
    // activates: R2 R3 R9 R10
    issue(ACT, 0, 3'd0, "R11 first ACT");
    issue(ACT, 1, 3'd4, "R2 ACT gap 1");
    idle(3, 0);
    issue(ACT, 2, 3'd0, "R2 ACT gap 4 floor");
    idle(3, 0);
    issue(ACT, 3, 3'd0, "R2 ACT gap 4");
    idle(3, 0);
    issue(ACT, 4, 3'd3, "R3 fifth ACT in window");
    idle(7, 0);
    issue(ACT, 5, 3'd0, "R10 R3 window equal");
    idle(2, 0);
    issue(ACT, 6, 3'd3, "R9 FAW over RRD");
    idle(3, 0);
    // column: R4 R5 R6
    issue(WR, 0, 3'd0, "R4 first WR");
    idle(3, 0);
    issue(RD, 0, 3'd5, "R5 RD too close to WR");
    idle(3, 0);
    issue(WR, 1, 3'd0, "R4 col gap 4");
    idle(12, 0);
    issue(RD, 1, 3'd0, "R5 RD at limit");
    idle(1, 0);
    issue(RD, 2, 3'd6, "R4 col gap 2");
    issue(PRE, 1, 3'd7, "R6 PRE after RD gap 3");
    issue(PRE, 0, 3'd0, "R6 other bank read ignored");
    idle(1, 0);
    issue(PRE, 2, 3'd0, "R6 PRE gap 4");
    issue(PRE, 3, 3'd0, "R6 PRE unread bank");
    idle(2, 0);
    // mode register: R7 R8 R10
    issue(MRS, 0, 3'd0, "R7 first MRS");
    idle(1, 0);
    issue(MRS, 0, 3'd2, "R7 MRS gap 2");
    idle(3, 0);
    issue(MRS, 0, 3'd0, "R7 MRS gap 4");
    idle(10, 0);
    issue(ACT, 0, 3'd1, "R8 ACT gap 11 after MRS");
    issue(RD, 0, 3'd0, "R8 RD gap 12 after MRS");
    issue(ACT, 1, 3'd4, "R10 flagged ACT recorded");
    idle(4, 0);
    issue(ACT, 2, 3'd0, "R2 ACT before reset");
    idle(2, 1);
    issue(ACT, 3, 3'd0, "R11 ACT after reset");
    idle(3, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule